// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a bus-based processor whose datapath is driven one register transfer per cycle. Every cycle it forms a lookup address from the registered macro-instruction opcode, the registered zero and busy status bits and the current microstate. It reads one control word from a computed table. Each word carries a 17-bit control-point vector for the datapath and the next microstate. Dispatch on the opcode, the branch on zero and the wait on a slow memory are all entries of that table. None of them has its own logic.

The sequencer has 25 microstates. Each is listed here with its code and its control vector in hex: FETCH0=0 (0x000E8), FETCH1=1 (0x000E2), FETCH2=2 (0x08001), FETCH3=3 (0x00AD0), ALU0=4 (0x00022), ALU1=5 (0x00064), ALU2=6 (0x00C90), ALUI0=7 (0x00022), ALUI1=8 (0x04004), ALUI2=9 (0x00C50), LW0=10 (0x00022), LW1=11 (0x04004), LW2=12 (0x00808), LW3=13 (0x08050), SW0=14 (0x00022), SW1=15 (0x04004), SW2=16 (0x00808), SW3=17 (0x18060), J0=18 (0x000E2), J1=19 (0x07004), J2=20 (0x00ED0), BZ0=21 (0x00022), BZT0=22 (0x000E2), BZT1=23 (0x05004), BZT2=24 (0x008D0). Codes 25 and above carry an all-zero vector and lead to FETCH0.

Transitions: FETCH0→FETCH1→FETCH2→FETCH3, then dispatch. Register ALU: ALU0→ALU1→ALU2→FETCH0. Immediate ALU: ALUI0→ALUI1→ALUI2→FETCH0. Load: LW0→LW1→LW2→LW3→FETCH0. Store: SW0→SW1→SW2→SW3→FETCH0. Jump: J0→J1→J2→FETCH0. Conditional branch: BZ0→BZT0 or FETCH0, then BZT0→BZT1→BZT2→FETCH0.

Top module: `ucode_seq`

## Requirements
- R1: A low level of rst_n at a rising clock edge sets the microstate to FETCH0 (code 0) and clears the registered opcode, zero and busy values to 0. The control vector is then 0x000E8.
- R2: The instruction fetch runs FETCH0, FETCH1, FETCH2, FETCH3. In these states ctl carries 0x000E8 (PC drives the bus, MA loads), 0x000E2 (PC drives the bus, A loads), 0x08001 (memory drives the bus, IR loads) and 0x00AD0 (ALU computes A+4 onto the bus and is written into the PC register).
- R3: FETCH2, LW3 and SW3 stay in place while the registered busy bit is 1. They move on at the first edge where it is 0. The control vector stays unchanged while they wait.
- R4: At FETCH3 the registered opcode selects the next state. 0x00 goes to ALU0, 0x08 to ALUI0, 0x23 to LW0, 0x2B to SW0, 0x02 to J0, and 0x04 or 0x05 to BZ0. Every other opcode goes back to FETCH0.
- R5: At BZ0 with registered opcode 0x05, the sequencer goes to BZT0 when the registered zero bit is 0. With any other registered opcode it goes to BZT0 when that bit is 1. In all remaining cases it goes to FETCH0. From BZT0 it runs BZT1, BZT2, FETCH0.
- R6: Each instruction body follows the transitions and control vectors listed above and ends in FETCH0.
- R7: opcode, zero and busy are registered at every edge. A value applied before edge k steers the transition taken at edge k+1.
- R8: At most one bus source is active in any cycle: ctl[5], ctl[11], ctl[14], or ctl[15] with ctl[16] clear. ctl[16] is never set without ctl[15].
- R9: The control vector layout is as follows:
  - ctl[0] loads IR; ctl[1] loads A; ctl[2] loads B; ctl[3] loads MA.
  - ctl[4] writes the register file; ctl[5] lets the register file drive the bus.
  - ctl[8:6] selects the register (0 rs, 1 rt, 2 rd, 3 PC).
  - ctl[10:9] selects the ALU operation (0 add, 1 A+4, 2 instruction function, 3 jump target); ctl[11] lets the ALU drive the bus.
  - ctl[13:12] selects the immediate form (0 sign-extended, 1 sign-extended shifted by two, 2 zero-extended, 3 26-bit jump field); ctl[14] lets the immediate drive the bus.
  - ctl[15] enables memory; ctl[16] selects a memory write.
- R10: In a state whose transition does not depend on an input, that input has no effect. For example, ALU1 goes to ALU2 and ALU2 goes to FETCH0 whatever the busy, zero and opcode values are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | OPC_W (6) | Opcode field of the instruction register |
| zero | input | 1 | Zero status from the datapath |
| busy | input | 1 | Memory busy status |
| ctl | output | 17 | Control-point vector for the current microstate |
| ustate | output | ST_W (5) | Current microstate code |

## Verification
Some behaviours are checked on every cycle after reset by assertions in the RTL:
- the ordering of the fetch states;
- holding in FETCH2 while busy is registered high;
- falling back to FETCH0 on an unlisted opcode;
- the taken branch out of BZ0;
- ALU1 ignoring its inputs;
- the single-bus-source rule.

Other behaviours only show through the bench's scenarios. These are the one-edge lag that the input registers add, a wait in a load that ends only one cycle after busy falls, and the full path of every instruction body with its control vectors. Long mixed runs with frequent opcode and status changes are compared against a reference next-state model.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int CTL_W    = 17;
    localparam int ST_MIN_W = 5;
    localparam int STAT_W   = 2;

    typedef enum logic [4:0] {
        S_FETCH0 = 5'd0,
        S_FETCH1 = 5'd1,
        S_FETCH2 = 5'd2,
        S_FETCH3 = 5'd3,
        S_ALU0   = 5'd4,
        S_ALU1   = 5'd5,
        S_ALU2   = 5'd6,
        S_ALUI0  = 5'd7,
        S_ALUI1  = 5'd8,
        S_ALUI2  = 5'd9,
        S_LW0    = 5'd10,
        S_LW1    = 5'd11,
        S_LW2    = 5'd12,
        S_LW3    = 5'd13,
        S_SW0    = 5'd14,
        S_SW1    = 5'd15,
        S_SW2    = 5'd16,
        S_SW3    = 5'd17,
        S_J0     = 5'd18,
        S_J1     = 5'd19,
        S_J2     = 5'd20,
        S_BZ0    = 5'd21,
        S_BZT0   = 5'd22,
        S_BZT1   = 5'd23,
        S_BZT2   = 5'd24
    } ustate_e;

    // register select codes
    localparam logic [2:0] RS_RS = 3'd0;
    localparam logic [2:0] RS_RT = 3'd1;
    localparam logic [2:0] RS_RD = 3'd2;
    localparam logic [2:0] RS_PC = 3'd3;

    // ALU operation codes
    localparam logic [1:0] AF_ADD  = 2'd0;
    localparam logic [1:0] AF_INC4 = 2'd1;
    localparam logic [1:0] AF_FUNC = 2'd2;
    localparam logic [1:0] AF_JTGT = 2'd3;

    // immediate forms
    localparam logic [1:0] IM_SEXT = 2'd0;
    localparam logic [1:0] IM_SX2  = 2'd1;
    localparam logic [1:0] IM_ZEXT = 2'd2;
    localparam logic [1:0] IM_J26  = 2'd3;

    // opcodes of the encoded subset
    localparam int unsigned OP_ALU  = 32'h00;
    localparam int unsigned OP_J    = 32'h02;
    localparam int unsigned OP_BEQZ = 32'h04;
    localparam int unsigned OP_BNEZ = 32'h05;
    localparam int unsigned OP_ALUI = 32'h08;
    localparam int unsigned OP_LW   = 32'h23;
    localparam int unsigned OP_SW   = 32'h2B;

    typedef struct packed {
        logic       mem_write;
        logic       mem_drive;
        logic       imm_drive;
        logic [1:0] imm_mode;
        logic       alu_drive;
        logic [1:0] alu_fn;
        logic [2:0] rf_sel;
        logic       rf_drive;
        logic       rf_write;
        logic       ma_load;
        logic       b_load;
        logic       a_load;
        logic       ir_load;
    } uctl_t;

    function automatic ustate_e op_target(input int unsigned op);
        ustate_e t;
        case (op)
            OP_ALU:          t = S_ALU0;
            OP_ALUI:         t = S_ALUI0;
            OP_LW:           t = S_LW0;
            OP_SW:           t = S_SW0;
            OP_J:            t = S_J0;
            OP_BEQZ, OP_BNEZ: t = S_BZ0;
            default:         t = S_FETCH0;
        endcase
        return t;
    endfunction

    function automatic bit op_known(input int unsigned op);
        return op_target(op) != S_FETCH0;
    endfunction

    // register file drives the bus into a latch
    function automatic uctl_t rf_to(input logic [2:0] sel, input logic to_a,
                                    input logic to_b, input logic to_ma);
        uctl_t c = '0;
        c.rf_sel   = sel;
        c.rf_drive = 1'b1;
        c.a_load   = to_a;
        c.b_load   = to_b;
        c.ma_load  = to_ma;
        return c;
    endfunction

    // ALU result onto the bus, written to register or MA
    function automatic uctl_t alu_to(input logic [1:0] fn, input logic [2:0] sel,
                                     input logic wr, input logic to_ma);
        uctl_t c = '0;
        c.alu_fn    = fn;
        c.alu_drive = 1'b1;
        c.rf_sel    = sel;
        c.rf_write  = wr;
        c.ma_load   = to_ma;
        return c;
    endfunction

    function automatic uctl_t imm_to_b(input logic [1:0] mode);
        uctl_t c = '0;
        c.imm_mode  = mode;
        c.imm_drive = 1'b1;
        c.b_load    = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/useq_inreg.sv
module useq_inreg
    import useq_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter bit REG_IN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opc_i,
    input  logic             zero_i,
    input  logic             busy_i,
    output logic [OPC_W-1:0] opc_o,
    output logic             zero_o,
    output logic             busy_o
);

    generate
        if (REG_IN) begin : g_reg
            logic [OPC_W-1:0] opc_q;
            logic             zero_q;
            logic             busy_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    opc_q  <= '0;
                    zero_q <= 1'b0;
                    busy_q <= 1'b0;
                end else begin
                    opc_q  <= opc_i;
                    zero_q <= zero_i;
                    busy_q <= busy_i;
                end
            end

            assign opc_o  = opc_q;
            assign zero_o = zero_q;
            assign busy_o = busy_q;
        end else begin : g_pass
            assign opc_o  = opc_i;
            assign zero_o = zero_i;
            assign busy_o = busy_i;
        end
    endgenerate

endmodule

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int ST_W  = 5,
    localparam int AW   = OPC_W + STAT_W + ST_W,
    localparam int DW   = CTL_W + ST_W
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);

    // address fields: {opcode, zero, busy, microstate}
    logic [ST_W-1:0]  a_st;
    logic             a_busy;
    logic             a_zero;
    logic [OPC_W-1:0] a_opc;
    logic             a_legal;
    ustate_e          cur;
    ustate_e          nxt;
    uctl_t            c;

    assign a_st    = addr[ST_W-1:0];
    assign a_busy  = addr[ST_W];
    assign a_zero  = addr[ST_W+1];
    assign a_opc   = addr[AW-1:ST_W+STAT_W];
    assign a_legal = ((a_st >> ST_MIN_W) == '0) && (a_st[ST_MIN_W-1:0] <= 5'(S_BZT2));
    assign cur     = ustate_e'(a_st[ST_MIN_W-1:0]);

    always_comb begin
        c   = '0;
        nxt = S_FETCH0;
        if (a_legal) begin
            unique case (cur)
                S_FETCH0: begin c = rf_to(RS_PC, 1'b0, 1'b0, 1'b1); nxt = S_FETCH1; end
                S_FETCH1: begin c = rf_to(RS_PC, 1'b1, 1'b0, 1'b0); nxt = S_FETCH2; end
                S_FETCH2: begin
                    c.mem_drive = 1'b1;
                    c.ir_load   = 1'b1;
                    nxt = a_busy ? S_FETCH2 : S_FETCH3;
                end
                S_FETCH3: begin
                    c   = alu_to(AF_INC4, RS_PC, 1'b1, 1'b0);
                    nxt = op_target(32'(a_opc));
                end
                S_ALU0:  begin c = rf_to(RS_RS, 1'b1, 1'b0, 1'b0); nxt = S_ALU1; end
                S_ALU1:  begin c = rf_to(RS_RT, 1'b0, 1'b1, 1'b0); nxt = S_ALU2; end
                S_ALU2:  begin c = alu_to(AF_FUNC, RS_RD, 1'b1, 1'b0); nxt = S_FETCH0; end
                S_ALUI0: begin c = rf_to(RS_RS, 1'b1, 1'b0, 1'b0); nxt = S_ALUI1; end
                S_ALUI1: begin c = imm_to_b(IM_SEXT); nxt = S_ALUI2; end
                S_ALUI2: begin c = alu_to(AF_FUNC, RS_RT, 1'b1, 1'b0); nxt = S_FETCH0; end
                S_LW0:   begin c = rf_to(RS_RS, 1'b1, 1'b0, 1'b0); nxt = S_LW1; end
                S_LW1:   begin c = imm_to_b(IM_SEXT); nxt = S_LW2; end
                S_LW2:   begin c = alu_to(AF_ADD, RS_RS, 1'b0, 1'b1); nxt = S_LW3; end
                S_LW3: begin
                    c.mem_drive = 1'b1;
                    c.rf_sel    = RS_RT;
                    c.rf_write  = 1'b1;
                    nxt = a_busy ? S_LW3 : S_FETCH0;
                end
                S_SW0:   begin c = rf_to(RS_RS, 1'b1, 1'b0, 1'b0); nxt = S_SW1; end
                S_SW1:   begin c = imm_to_b(IM_SEXT); nxt = S_SW2; end
                S_SW2:   begin c = alu_to(AF_ADD, RS_RS, 1'b0, 1'b1); nxt = S_SW3; end
                S_SW3: begin
                    c.rf_sel    = RS_RT;
                    c.rf_drive  = 1'b1;
                    c.mem_drive = 1'b1;
                    c.mem_write = 1'b1;
                    nxt = a_busy ? S_SW3 : S_FETCH0;
                end
                S_J0:    begin c = rf_to(RS_PC, 1'b1, 1'b0, 1'b0); nxt = S_J1; end
                S_J1:    begin c = imm_to_b(IM_J26); nxt = S_J2; end
                S_J2:    begin c = alu_to(AF_JTGT, RS_PC, 1'b1, 1'b0); nxt = S_FETCH0; end
                S_BZ0: begin
                    c = rf_to(RS_RS, 1'b1, 1'b0, 1'b0);
                    if (32'(a_opc) == OP_BNEZ) nxt = a_zero ? S_FETCH0 : S_BZT0;
                    else                       nxt = a_zero ? S_BZT0 : S_FETCH0;
                end
                S_BZT0:  begin c = rf_to(RS_PC, 1'b1, 1'b0, 1'b0); nxt = S_BZT1; end
                S_BZT1:  begin c = imm_to_b(IM_SX2); nxt = S_BZT2; end
                S_BZT2:  begin c = alu_to(AF_ADD, RS_PC, 1'b1, 1'b0); nxt = S_FETCH0; end
                default: begin c = '0; nxt = S_FETCH0; end
            endcase
        end
    end

    assign word = {ST_W'(nxt), c};

endmodule

// File: rtl/useq_state.sv
module useq_state
    import useq_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int ST_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ST_W-1:0]  nxt_i,
    input  logic [OPC_W-1:0] opc_q,
    input  logic             zero_q,
    input  logic             busy_q,
    output logic [ST_W-1:0]  st_o
);

    localparam logic [ST_W-1:0] C_F0   = ST_W'(S_FETCH0);
    localparam logic [ST_W-1:0] C_F1   = ST_W'(S_FETCH1);
    localparam logic [ST_W-1:0] C_F2   = ST_W'(S_FETCH2);
    localparam logic [ST_W-1:0] C_F3   = ST_W'(S_FETCH3);
    localparam logic [ST_W-1:0] C_A1   = ST_W'(S_ALU1);
    localparam logic [ST_W-1:0] C_A2   = ST_W'(S_ALU2);
    localparam logic [ST_W-1:0] C_BZ0  = ST_W'(S_BZ0);
    localparam logic [ST_W-1:0] C_BZT0 = ST_W'(S_BZT0);

    logic [ST_W-1:0] st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= C_F0;
        else        st_q <= nxt_i;
    end

    assign st_o = st_q;

    p_reset_fetch_r1: assert property (@(posedge clk)
        !rst_n |=> (st_q == C_F0));

    p_fetch_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_F0) |=> (st_q == C_F1));

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_F2 && busy_q) |=> (st_q == C_F2));

    p_busy_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_F2 && !busy_q) |=> (st_q == C_F3));

    p_unknown_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_F3 && !op_known(32'(opc_q))) |=> (st_q == C_F0));

    p_bz_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_BZ0 && ((32'(opc_q) == OP_BNEZ) ? !zero_q : zero_q))
        |=> (st_q == C_BZT0));

    p_ignore_inputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_A1) |=> (st_q == C_A2));

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import useq_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter int ST_W   = 5,
    parameter bit REG_IN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             zero,
    input  logic             busy,
    output logic [CTL_W-1:0] ctl,
    output logic [ST_W-1:0]  ustate
);

    localparam int AW = OPC_W + STAT_W + ST_W;
    localparam int DW = CTL_W + ST_W;

    generate
        if (ST_W < ST_MIN_W) begin : g_bad_width
            initial $error("ucode_seq: ST_W below minimum");
        end
    endgenerate

    logic [OPC_W-1:0] opc_q;
    logic             zero_q;
    logic             busy_q;
    logic [ST_W-1:0]  st;
    logic [AW-1:0]    rom_addr;
    logic [DW-1:0]    rom_word;
    uctl_t            c_out;

    useq_inreg #(.OPC_W(OPC_W), .REG_IN(REG_IN)) u_inreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .opc_i  (opcode),
        .zero_i (zero),
        .busy_i (busy),
        .opc_o  (opc_q),
        .zero_o (zero_q),
        .busy_o (busy_q)
    );

    assign rom_addr = {opc_q, zero_q, busy_q, st};

    useq_rom #(.OPC_W(OPC_W), .ST_W(ST_W)) u_rom (
        .addr (rom_addr),
        .word (rom_word)
    );

    useq_state #(.OPC_W(OPC_W), .ST_W(ST_W)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_i  (rom_word[DW-1:CTL_W]),
        .opc_q  (opc_q),
        .zero_q (zero_q),
        .busy_q (busy_q),
        .st_o   (st)
    );

    always_comb begin
        c_out = uctl_t'(rom_word[CTL_W-1:0]);
    end

    assign ctl    = c_out;
    assign ustate = st;

    p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({c_out.rf_drive, c_out.alu_drive, c_out.imm_drive,
                  c_out.mem_drive & ~c_out.mem_write}));

    p_write_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_out.mem_write |-> c_out.mem_drive);

endmodule

// File: tb/sim_ucode_seq.sv
module sim_ucode_seq;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic        zero  = 1'b0;
    logic        busy  = 1'b0;
    logic [16:0] ctl;
    logic [4:0]  ustate;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    int ms = 0;
    int mo = 0;
    bit mz = 1'b0;
    bit mb = 1'b0;

    always #10 clk = ~clk;

    ucode_seq u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .zero   (zero),
        .busy   (busy),
        .ctl    (ctl),
        .ustate (ustate)
    );

    function automatic int disp(input int op);
        case (op)
            'h00: return 4;
            'h08: return 7;
            'h23: return 10;
            'h2B: return 14;
            'h02: return 18;
            'h04, 'h05: return 21;
            default: return 0;
        endcase
    endfunction

    function automatic int nxt(input int s, input int op, input bit z, input bit b);
        case (s)
            0: return 1;
            1: return 2;
            2: return b ? 2 : 3;
            3: return disp(op);
            4: return 5;   5: return 6;   6: return 0;
            7: return 8;   8: return 9;   9: return 0;
            10: return 11; 11: return 12; 12: return 13;
            13: return b ? 13 : 0;
            14: return 15; 15: return 16; 16: return 17;
            17: return b ? 17 : 0;
            18: return 19; 19: return 20; 20: return 0;
            21: return ((op == 'h05) ? !z : z) ? 22 : 0;
            22: return 23; 23: return 24; 24: return 0;
            default: return 0;
        endcase
    endfunction

    function automatic logic [16:0] exp_ctl(input int s);
        case (s)
            0: return 17'h000E8;  1: return 17'h000E2;
            2: return 17'h08001;  3: return 17'h00AD0;
            4, 7, 10, 14, 21: return 17'h00022;
            5: return 17'h00064;  6: return 17'h00C90;
            8, 11, 15: return 17'h04004;
            9: return 17'h00C50;
            12, 16: return 17'h00808;
            13: return 17'h08050; 17: return 17'h18060;
            18, 22: return 17'h000E2;
            19: return 17'h07004; 20: return 17'h00ED0;
            23: return 17'h05004; 24: return 17'h008D0;
            default: return 17'h0;
        endcase
    endfunction

    function automatic string req_of(input int s);
        if (s <= 3) return "R2";
        if (s >= 21) return "R5";
        return "R6";
    endfunction

    task automatic step(input logic [5:0] o, input logic z, input logic b);
        opcode = o;
        zero   = z;
        busy   = b;
        @(posedge clk);
        if (!rst_n) begin
            ms = 0; mo = 0; mz = 1'b0; mb = 1'b0;
        end else begin
            ms = nxt(ms, mo, mz, mb);
            mo = int'(o); mz = z; mb = b;
        end
        @(negedge clk);
    endtask

    task automatic chk(input string tag);
        int drv;
        n_chk++;
        if (int'(ustate) != ms) begin
            n_fail++;
            $display("FAIL %s state: actual %0d expected %0d", tag, ustate, ms);
        end
        n_chk++;
        if (ctl !== exp_ctl(ms)) begin
            n_fail++;
            $display("FAIL %s/R9 ctl: actual %h expected %h", tag, ctl, exp_ctl(ms));
        end
        drv = int'(ctl[5]) + int'(ctl[11]) + int'(ctl[14]) + int'(ctl[15] & ~ctl[16]);
        n_chk++;
        if (drv > 1 || (ctl[16] && !ctl[15])) begin
            n_fail++;
            $display("FAIL R8 bus sources: actual %0d expected <=1", drv);
        end
    endtask

    task automatic chk_lit(input string tag, input int want);
        n_chk++;
        if (int'(ustate) != want) begin
            n_fail++;
            $display("FAIL %s literal state: actual %0d expected %0d", tag, ustate, want);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [5:0] op;
        void'($urandom(32'd5521));
        #5;
        // R1: reset state
        rst_n = 1'b0;
        step(6'h00, 1'b0, 1'b0);
        step(6'h00, 1'b0, 1'b0);
        chk("R1");
        chk_lit("R1", 0);
        rst_n = 1'b1;

        // R2, R3, R7: fetch held by busy, release lags one edge
        step(6'h00, 1'b0, 1'b1); chk("R2"); chk_lit("R2", 1);
        step(6'h00, 1'b0, 1'b1); chk("R2"); chk_lit("R2", 2);
        step(6'h00, 1'b0, 1'b1); chk("R3"); chk_lit("R3", 2);
        step(6'h00, 1'b0, 1'b1); chk("R3"); chk_lit("R3", 2);
        step(6'h00, 1'b0, 1'b0); chk("R7"); chk_lit("R7", 2);
        step(6'h00, 1'b0, 1'b0); chk("R3"); chk_lit("R3", 3);
        step(6'h00, 1'b0, 1'b0); chk("R4"); chk_lit("R4", 4);
        // R10: busy ignored in ALU body
        step(6'h00, 1'b0, 1'b1); chk("R10"); chk_lit("R10", 5);
        step(6'h00, 1'b1, 1'b1); chk("R10"); chk_lit("R10", 6);
        step(6'h00, 1'b0, 1'b0); chk("R10"); chk_lit("R10", 0);

        // R4: unlisted opcode returns to fetch
        step(6'h3F, 1'b0, 1'b0); chk("R2");
        step(6'h3F, 1'b0, 1'b0); chk("R2");
        step(6'h3F, 1'b0, 1'b0); chk("R2"); chk_lit("R4", 3);
        step(6'h3F, 1'b0, 1'b0); chk("R4"); chk_lit("R4", 0);

        // R5: branch if zero, taken
        for (int i = 0; i < 4; i++) begin step(6'h04, 1'b1, 1'b0); chk("R5"); end
        chk_lit("R5", 21);
        step(6'h04, 1'b1, 1'b0); chk("R5"); chk_lit("R5", 22);
        for (int i = 0; i < 3; i++) begin step(6'h04, 1'b1, 1'b0); chk("R5"); end
        chk_lit("R5", 0);

        // R5: branch if not zero with zero set, not taken
        for (int i = 0; i < 4; i++) begin step(6'h05, 1'b1, 1'b0); chk("R5"); end
        step(6'h05, 1'b1, 1'b0); chk("R5"); chk_lit("R5", 0);

        // R3, R6: load waits on memory
        for (int i = 0; i < 6; i++) begin step(6'h23, 1'b0, 1'b0); chk("R6"); end
        chk_lit("R6", 12);
        step(6'h23, 1'b0, 1'b1); chk("R6"); chk_lit("R6", 13);
        step(6'h23, 1'b0, 1'b1); chk("R3"); chk_lit("R3", 13);
        step(6'h23, 1'b0, 1'b0); chk("R7"); chk_lit("R7", 13);
        step(6'h23, 1'b0, 1'b0); chk("R3"); chk_lit("R3", 0);

        // mixed random run with occasional resets (R1..R10)
        for (int i = 0; i < 4000; i++) begin
            rst_n = ($urandom_range(0, 299) != 0);
            case ($urandom_range(0, 7))
                0: op = 6'h00;
                1: op = 6'h08;
                2: op = 6'h23;
                3: op = 6'h2B;
                4: op = 6'h02;
                5: op = 6'h04;
                6: op = 6'h05;
                default: op = 6'($urandom_range(0, 63));
            endcase
            step(op, 1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0));
            chk(rst_n ? req_of(ms) : "R1");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule